// File: doc/BRIEF.md
# Clock Operating Mode Controller

This block holds the CPU clock operating mode of a small microcontroller and chooses the clock source and divider that feed the processor. Software asks for a target mode together with a divider code and a PLL multiplier code. A route checker judges each request against the allowed transitions and the ready flags of the oscillators. A legal request is applied on the next clock edge. An illegal request changes nothing except that a sticky error flag is set. The controller also keeps a divide-by-8 override flag, reports which oscillators must run, and reports whether the peripheral clocks come from the main clock or from the on-chip oscillator.

There are seven states: MED (main clock, divided), HIGH (main clock, undivided), PLL (main clock multiplied), LOW (sub clock), LPD (sub clock with the main clock stopped), OCO (on-chip oscillator, divided) and OCOLP (on-chip oscillator with the main clock stopped). The named transitions are:
- enter_pll: HIGH to PLL.
- leave_pll: PLL to HIGH.
- to_low: MED, HIGH or LPD to LOW.
- stop_main: LOW to LPD.
- wake_main: LPD to MED at divide-by-8.
- to_oco: MED or HIGH to OCO.
- oco_sleep and oco_wake: between OCO and OCOLP.
- oco_exit: OCO to MED at divide-by-8.
- speed_change: among MED and HIGH, and from LOW to MED or HIGH.
- retune: a request for the same mode, used to change a divider (MED, OCO) or to repeat LOW, LPD or OCOLP.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the mode is MED (code 0), the divide-by-8 flag is 1, the effective divider code is 3, the main clock enable is 1, the sub, PLL and on-chip oscillator enables are 0, the multiplier code is 0 and the error flag is 0.
- R2: Mode codes are MED=0, HIGH=1, PLL=2, LOW=3, LPD=4, OCO=5, OCOLP=6. Source codes are main=0, sub=1, PLL=2, on-chip oscillator=3. Divider codes 0..4 mean /1, /2, /4, /8, /16. MED and HIGH select main. HIGH reports divider 0. In MED, OCO and OCOLP the divider output is 3 while the flag is 1, and the stored divider otherwise. PLL, LOW and LPD report divider 0.
- R3: PLL is entered only from HIGH, and latches the multiplier code (0..3 = x2, x4, x6, x8). From PLL the only legal target is HIGH; a request for PLL while already in PLL is rejected.
- R4: OCO selects source 3 with the requested divider code and clears the flag. OCOLP entered from OCO, and OCO entered from OCOLP, keep the divider and the flag. The peripheral-from-oscillator output is 1 in both on-chip oscillator modes.
- R5: LPD is reached only from LOW (or LPD itself). In LPD the main enable is 0 and the flag is forced to 1. From LPD the only legal exits are LOW and MED with divider code 3.
- R6: Any request from LOW or LPD to OCO or OCOLP is rejected. Any request from OCO or OCOLP to LOW or LPD is also rejected.
- R7: From OCO the only main-clock destination is MED with divider code 3. It is legal only while the flag is 1. OCOLP has no main-clock destination.
- R8: A request is accepted only when the ready input of its target source is 1. MED and HIGH need main_rdy, PLL needs pll_rdy, LOW and LPD need sub_rdy, and OCO and OCOLP need oco_rdy. LOW entered from LPD also needs main_rdy.
- R9: A rejected request sets req_err and leaves every other output unchanged. req_err stays 1 until err_clr is given in a cycle with no rejection; a rejection in the same cycle wins.
- R10: In LOW and LPD the peripheral-from-oscillator output equals the software on-chip oscillator enable bit. In MED, HIGH and PLL it is 0.
- R11: An osc_wr write stores osc_wdata bit 0 = sub, bit 1 = PLL and bit 2 = on-chip oscillator enable. Each enable output is the stored bit ORed with the need of the current mode. The main enable is 0 exactly in LPD and OCOLP.
- R12: A mode code of 7 is rejected. A divider code above 4 is rejected for MED and OCO. Code 0 is rejected for MED.
- R13: A div8_wr write sets the flag to div8_wdata only in MED, LOW, OCO and OCOLP, and only in a cycle with no request. It is ignored in HIGH, PLL and LPD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| req_div | input | DIV_W | Requested divider code |
| req_mul | input | MUL_W | Requested PLL multiplier code |
| div8_wr | input | 1 | Write strobe for the divide-by-8 flag |
| div8_wdata | input | 1 | New flag value |
| osc_wr | input | 1 | Write strobe for oscillator enable bits |
| osc_wdata | input | 3 | {oco, pll, sub} enable bits |
| err_clr | input | 1 | Clears the sticky error flag |
| main_rdy | input | 1 | Main clock stable |
| sub_rdy | input | 1 | Sub clock stable |
| pll_rdy | input | 1 | PLL locked |
| oco_rdy | input | 1 | On-chip oscillator stable |
| mode | output | 3 | Current mode code |
| cpu_src | output | 2 | CPU clock source code |
| cpu_div | output | DIV_W | Effective CPU divider code |
| pll_mul | output | MUL_W | Latched multiplier code |
| div8_flag | output | 1 | Divide-by-8 override flag |
| main_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Sub oscillator enable |
| pll_en | output | 1 | PLL enable |
| oco_en | output | 1 | On-chip oscillator enable |
| per_oco | output | 1 | Peripheral clocks taken from the on-chip oscillator |
| req_err | output | 1 | Sticky rejected-request flag |

## Verification
The bench goes after the forbidden routes. A design with a missing route check would move straight between the sub-clock and on-chip oscillator groups, leave PLL for MED, or leave OCO for a main-clock mode without the flag. It also covers the flag rules. A design that got them wrong would let a flag write in LPD clear the lock, or let a write that collides with a request change the divider. It checks that a request whose source is not ready is refused rather than applied. It also checks that an error clear arriving with a new rejection leaves the error set. A long random phase walks all routes and ready combinations against a behavioural model every clock.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    typedef enum logic [2:0] {
        M_MED   = 3'd0,
        M_HIGH  = 3'd1,
        M_PLL   = 3'd2,
        M_LOW   = 3'd3,
        M_LPD   = 3'd4,
        M_OCO   = 3'd5,
        M_OCOLP = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        S_MAIN = 2'd0,
        S_SUB  = 2'd1,
        S_PLL  = 2'd2,
        S_OCO  = 2'd3
    } src_e;

    localparam logic [2:0] LAST_MODE_CODE = 3'd6;

    function automatic logic in_sub_group(mode_e m);
        return (m == M_LOW) || (m == M_LPD);
    endfunction

    function automatic logic in_oco_group(mode_e m);
        return (m == M_OCO) || (m == M_OCOLP);
    endfunction

    function automatic logic uses_divider(mode_e m);
        return (m == M_MED) || in_oco_group(m);
    endfunction

endpackage

// File: rtl/ckm_route_check.sv
module ckm_route_check
    import ckm_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int DIV_MAX   = 4,
    parameter int DIV8_CODE = 3
) (
    input  mode_e              cur_mode,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [DIV_W-1:0]   req_div,
    input  logic               flag,
    input  logic               main_rdy,
    input  logic               sub_rdy,
    input  logic               pll_rdy,
    input  logic               oco_rdy,
    output logic               accept
);

    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(DIV_MAX);
    localparam logic [DIV_W-1:0] DIV_BY8 = DIV_W'(DIV8_CODE);

    mode_e tgt;
    logic  code_ok;
    logic  route_ok;
    logic  rdy_ok;
    logic  div_ok;

    // route table: which targets each state may request
    always_comb begin
        code_ok  = (req_mode <= LAST_MODE_CODE);
        tgt      = mode_e'(req_mode);
        route_ok = 1'b0;
        unique case (cur_mode)
            M_MED:   route_ok = (tgt == M_MED) || (tgt == M_HIGH) ||
                                (tgt == M_LOW) || (tgt == M_OCO);
            M_HIGH:  route_ok = (tgt == M_MED) || (tgt == M_HIGH) ||
                                (tgt == M_PLL) || (tgt == M_LOW)  ||
                                (tgt == M_OCO);
            M_PLL:   route_ok = (tgt == M_HIGH);
            M_LOW:   route_ok = (tgt == M_MED) || (tgt == M_HIGH) ||
                                (tgt == M_LOW) || (tgt == M_LPD);
            M_LPD:   route_ok = (tgt == M_MED) || (tgt == M_LOW) ||
                                (tgt == M_LPD);
            M_OCO:   route_ok = (tgt == M_OCO) || (tgt == M_OCOLP) ||
                                ((tgt == M_MED) && flag);
            M_OCOLP: route_ok = (tgt == M_OCO) || (tgt == M_OCOLP);
            default: route_ok = 1'b0;
        endcase
    end

    // source readiness of the destination
    always_comb begin
        rdy_ok = 1'b0;
        case (tgt)
            M_MED, M_HIGH:  rdy_ok = main_rdy;
            M_PLL:          rdy_ok = pll_rdy;
            M_LOW:          rdy_ok = sub_rdy && ((cur_mode != M_LPD) || main_rdy);
            M_LPD:          rdy_ok = sub_rdy;
            M_OCO, M_OCOLP: rdy_ok = oco_rdy;
            default:        rdy_ok = 1'b0;
        endcase
    end

    // divider code checks; leaving LPD or OCO for MED forces divide-by-8
    always_comb begin
        div_ok = 1'b1;
        case (tgt)
            M_MED: begin
                div_ok = (req_div != '0) && (req_div <= DIV_TOP);
                if ((cur_mode == M_LPD) || (cur_mode == M_OCO)) begin
                    div_ok = (req_div == DIV_BY8);
                end
            end
            M_OCO:   div_ok = (req_div <= DIV_TOP);
            default: div_ok = 1'b1;
        endcase
    end

    assign accept = req_valid && code_ok && route_ok && rdy_ok && div_ok;

endmodule

// File: rtl/ckm_mode_fsm.sv
module ckm_mode_fsm
    import ckm_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int MUL_W     = 2,
    parameter int DIV8_CODE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [DIV_W-1:0]   req_div,
    input  logic [MUL_W-1:0]   req_mul,
    input  logic               accept,
    input  logic               div8_wr,
    input  logic               div8_wdata,
    input  logic               err_clr,
    output mode_e              mode_q,
    output logic               flag_q,
    output logic [DIV_W-1:0]   div_q,
    output logic [MUL_W-1:0]   mul_q,
    output logic               err_q
);

    localparam logic [DIV_W-1:0] DIV_BY8 = DIV_W'(DIV8_CODE);

    mode_e            mode_d;
    mode_e            tgt;
    logic             flag_d;
    logic [DIV_W-1:0] div_d;
    logic [MUL_W-1:0] mul_d;
    logic             err_d;
    logic             reject;
    logic             flag_writable;

    assign reject        = req_valid && !accept;
    assign flag_writable = (mode_q == M_MED) || (mode_q == M_LOW) || in_oco_group(mode_q);
    assign tgt           = mode_e'(req_mode);

    // next-state process
    always_comb begin
        mode_d = mode_q;
        flag_d = flag_q;
        div_d  = div_q;
        mul_d  = mul_q;
        if (req_valid) begin
            if (accept) begin
                mode_d = tgt;
                unique case (tgt)
                    M_MED: begin
                        div_d  = req_div;
                        flag_d = (req_div == DIV_BY8);
                    end
                    M_HIGH:  flag_d = 1'b0;
                    M_PLL:   mul_d  = req_mul;
                    M_LPD:   flag_d = 1'b1;
                    M_OCO: begin
                        if (mode_q != M_OCOLP) begin
                            div_d  = req_div;
                            flag_d = 1'b0;
                        end
                    end
                    M_LOW, M_OCOLP: begin
                    end
                    default: begin
                    end
                endcase
            end
        end else if (div8_wr && flag_writable) begin
            flag_d = div8_wdata;
        end
        err_d = reject ? 1'b1 : (err_clr ? 1'b0 : err_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_MED;
            flag_q <= 1'b1;
            div_q  <= DIV_BY8;
            mul_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            flag_q <= flag_d;
            div_q  <= div_d;
            mul_q  <= mul_d;
            err_q  <= err_d;
        end
    end

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !accept) |=> ($stable(mode_q) && $stable(div_q) && err_q)); // R9
    AST_PLL_ONLY_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q != M_PLL) && (mode_q != M_HIGH)) |=> (mode_q != M_PLL)); // R3
    AST_PLL_EXIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PLL) |=> ((mode_q == M_PLL) || (mode_q == M_HIGH))); // R3
    AST_LPD_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sub_group(mode_q) |=> (mode_q != M_LPD)); // R5
    AST_LPD_FLAG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_LPD) |-> flag_q); // R5
    AST_SUB_TO_OCO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        in_sub_group(mode_q) |=> !in_oco_group(mode_q)); // R6
    AST_OCO_TO_SUB_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        in_oco_group(mode_q) |=> !in_sub_group(mode_q)); // R6
    AST_OCO_EXIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_OCO) && !flag_q) |=> (mode_q != M_MED)); // R7

endmodule

// File: rtl/ckm_clk_decode.sv
module ckm_clk_decode
    import ckm_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int DIV8_CODE = 3
) (
    input  mode_e              mode_q,
    input  logic               flag_q,
    input  logic [DIV_W-1:0]   div_q,
    output logic [1:0]         cpu_src,
    output logic [DIV_W-1:0]   cpu_div
);

    localparam logic [DIV_W-1:0] DIV_BY8 = DIV_W'(DIV8_CODE);

    src_e src;

    // output process: source and effective divider per state
    always_comb begin
        src     = S_MAIN;
        cpu_div = '0;
        unique case (mode_q)
            M_MED:          src = S_MAIN;
            M_HIGH:         src = S_MAIN;
            M_PLL:          src = S_PLL;
            M_LOW, M_LPD:   src = S_SUB;
            M_OCO, M_OCOLP: src = S_OCO;
            default:        src = S_MAIN;
        endcase
        if (uses_divider(mode_q)) begin
            cpu_div = flag_q ? DIV_BY8 : div_q;
        end
    end

    assign cpu_src = src;

endmodule

// File: rtl/ckm_osc_ctl.sv
module ckm_osc_ctl
    import ckm_pkg::*;
#(
    parameter int OSC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              mode_q,
    input  logic               osc_wr,
    input  logic [OSC_W-1:0]   osc_wdata,
    output logic               main_en,
    output logic               sub_en,
    output logic               pll_en,
    output logic               oco_en,
    output logic               per_oco
);

    localparam int B_SUB = 0;
    localparam int B_PLL = 1;
    localparam int B_OCO = 2;

    logic [OSC_W-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (osc_wr) begin
            en_q <= osc_wdata;
        end
    end

    // enable = software bit OR need of current state
    always_comb begin
        main_en = !((mode_q == M_LPD) || (mode_q == M_OCOLP));
        sub_en  = en_q[B_SUB] || in_sub_group(mode_q);
        pll_en  = en_q[B_PLL] || (mode_q == M_PLL);
        oco_en  = en_q[B_OCO] || in_oco_group(mode_q);
        per_oco = in_oco_group(mode_q) || (in_sub_group(mode_q) && en_q[B_OCO]);
    end

    AST_OSC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_wr && osc_wdata[B_SUB]) |=> sub_en); // R11
    AST_PER_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sub_group(mode_q) && per_oco) |-> oco_en); // R10

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import ckm_pkg::*;
#(
    parameter int DIV_W      = 3,
    parameter int MUL_W      = 2,
    parameter int DIV_LEVELS = 5,
    parameter int DIV8_CODE  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [DIV_W-1:0]   req_div,
    input  logic [MUL_W-1:0]   req_mul,
    input  logic               div8_wr,
    input  logic               div8_wdata,
    input  logic               osc_wr,
    input  logic [2:0]         osc_wdata,
    input  logic               err_clr,
    input  logic               main_rdy,
    input  logic               sub_rdy,
    input  logic               pll_rdy,
    input  logic               oco_rdy,
    output logic [2:0]         mode,
    output logic [1:0]         cpu_src,
    output logic [DIV_W-1:0]   cpu_div,
    output logic [MUL_W-1:0]   pll_mul,
    output logic               div8_flag,
    output logic               main_en,
    output logic               sub_en,
    output logic               pll_en,
    output logic               oco_en,
    output logic               per_oco,
    output logic               req_err
);

    localparam int DIV_MAX = DIV_LEVELS - 1;

    mode_e            mode_q;
    logic             flag_q;
    logic [DIV_W-1:0] div_q;
    logic             accept;

    ckm_route_check #(
        .DIV_W     (DIV_W),
        .DIV_MAX   (DIV_MAX),
        .DIV8_CODE (DIV8_CODE)
    ) u_route (
        .cur_mode  (mode_q),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .req_div   (req_div),
        .flag      (flag_q),
        .main_rdy  (main_rdy),
        .sub_rdy   (sub_rdy),
        .pll_rdy   (pll_rdy),
        .oco_rdy   (oco_rdy),
        .accept    (accept)
    );

    ckm_mode_fsm #(
        .DIV_W     (DIV_W),
        .MUL_W     (MUL_W),
        .DIV8_CODE (DIV8_CODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_div    (req_div),
        .req_mul    (req_mul),
        .accept     (accept),
        .div8_wr    (div8_wr),
        .div8_wdata (div8_wdata),
        .err_clr    (err_clr),
        .mode_q     (mode_q),
        .flag_q     (flag_q),
        .div_q      (div_q),
        .mul_q      (pll_mul),
        .err_q      (req_err)
    );

    ckm_clk_decode #(
        .DIV_W     (DIV_W),
        .DIV8_CODE (DIV8_CODE)
    ) u_decode (
        .mode_q  (mode_q),
        .flag_q  (flag_q),
        .div_q   (div_q),
        .cpu_src (cpu_src),
        .cpu_div (cpu_div)
    );

    ckm_osc_ctl #(
        .OSC_W (3)
    ) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .osc_wr    (osc_wr),
        .osc_wdata (osc_wdata),
        .main_en   (main_en),
        .sub_en    (sub_en),
        .pll_en    (pll_en),
        .oco_en    (oco_en),
        .per_oco   (per_oco)
    );

    assign mode      = mode_q;
    assign div8_flag = flag_q;

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_div <= DIV_W'(DIV_MAX))); // R12
    AST_PLL_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src == 2'd2) |-> (pll_en && main_en)); // R11
    AST_LPD_MAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src == 2'd1 && !main_en) |-> div8_flag); // R5

endmodule

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic [2:0] req_div = '0;
    logic [1:0] req_mul = '0;
    logic       div8_wr = 1'b0;
    logic       div8_wdata = 1'b0;
    logic       osc_wr = 1'b0;
    logic [2:0] osc_wdata = '0;
    logic       err_clr = 1'b0;
    logic       main_rdy = 1'b1;
    logic       sub_rdy = 1'b1;
    logic       pll_rdy = 1'b1;
    logic       oco_rdy = 1'b1;
    logic [2:0] mode;
    logic [1:0] cpu_src;
    logic [2:0] cpu_div;
    logic [1:0] pll_mul;
    logic       div8_flag, main_en, sub_en, pll_en, oco_en, per_oco, req_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_mode, m_div, m_mul;
    bit m_flag, m_err, m_esub, m_epll, m_eoco, m_ok;

    clk_mode_ctrl u_clk_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_div(req_div), .req_mul(req_mul), .div8_wr(div8_wr),
        .div8_wdata(div8_wdata), .osc_wr(osc_wr), .osc_wdata(osc_wdata),
        .err_clr(err_clr), .main_rdy(main_rdy), .sub_rdy(sub_rdy),
        .pll_rdy(pll_rdy), .oco_rdy(oco_rdy), .mode(mode), .cpu_src(cpu_src),
        .cpu_div(cpu_div), .pll_mul(pll_mul), .div8_flag(div8_flag),
        .main_en(main_en), .sub_en(sub_en), .pll_en(pll_en), .oco_en(oco_en),
        .per_oco(per_oco), .req_err(req_err)
    );

    always #2.5 clk = ~clk;

    function automatic bit legal(int f, int t, int d, bit fl,
                                 bit mr, bit sr, bit pr, bit orr);
        if (t == 0) return mr && d >= 1 && d <= 4 &&
            (f == 0 || f == 1 || f == 3 || (f == 4 && d == 3) || (f == 5 && fl && d == 3));
        if (t == 1) return mr && (f <= 1 || f == 2 || f == 3);
        if (t == 2) return pr && f == 1;
        if (t == 3) return sr && (f == 0 || f == 1 || f == 3 || (f == 4 && mr));
        if (t == 4) return sr && (f == 3 || f == 4);
        if (t == 5) return orr && d <= 4 && (f == 0 || f == 1 || f == 5 || f == 6);
        if (t == 6) return orr && (f == 5 || f == 6);
        return 1'b0;
    endfunction

    function automatic int exp_src(int m);
        if (m <= 1) return 0;
        if (m == 2) return 2;
        if (m == 3 || m == 4) return 1;
        return 3;
    endfunction

    function automatic int exp_div(int m, bit fl, int d);
        if (m == 0 || m == 5 || m == 6) return fl ? 3 : d;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_flag = 1; m_div = 3; m_mul = 0; m_err = 0;
            m_esub = 0; m_epll = 0; m_eoco = 0;
        end else begin
            m_ok = legal(m_mode, int'(req_mode), int'(req_div), m_flag,
                         main_rdy, sub_rdy, pll_rdy, oco_rdy);
            if (req_valid && m_ok) begin
                case (int'(req_mode))
                    0: begin m_div = int'(req_div); m_flag = (req_div == 3); end
                    1: m_flag = 0;
                    2: m_mul = int'(req_mul);
                    4: m_flag = 1;
                    5: if (m_mode != 6) begin m_div = int'(req_div); m_flag = 0; end
                    default: ;
                endcase
                m_mode = int'(req_mode);
            end else if (!req_valid && div8_wr &&
                         (m_mode == 0 || m_mode == 3 || m_mode == 5 || m_mode == 6)) begin
                m_flag = div8_wdata;
            end
            if (req_valid && !m_ok) m_err = 1;
            else if (err_clr) m_err = 0;
            if (osc_wr) begin
                m_esub = osc_wdata[0]; m_epll = osc_wdata[1]; m_eoco = osc_wdata[2];
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2", "mode", int'(mode), m_mode);
            chk("R2", "cpu_src", int'(cpu_src), exp_src(m_mode));
            chk("R2", "cpu_div", int'(cpu_div), exp_div(m_mode, m_flag, m_div));
            chk("R3", "pll_mul", int'(pll_mul), m_mul);
            chk("R13", "div8_flag", int'(div8_flag), int'(m_flag));
            chk("R9", "req_err", int'(req_err), int'(m_err));
            chk("R11", "main_en", int'(main_en), int'(!(m_mode == 4 || m_mode == 6)));
            chk("R11", "sub_en", int'(sub_en), int'(m_esub || m_mode == 3 || m_mode == 4));
            chk("R11", "pll_en", int'(pll_en), int'(m_epll || m_mode == 2));
            chk("R11", "oco_en", int'(oco_en), int'(m_eoco || m_mode == 5 || m_mode == 6));
            chk("R10", "per_oco", int'(per_oco),
                int'(m_mode == 5 || m_mode == 6 || ((m_mode == 3 || m_mode == 4) && m_eoco)));
        end
    end

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            summary();
            $finish;
        end
    end

    task automatic request(int m, int d, int mu);
        req_valid = 1; req_mode = 3'(m); req_div = 3'(d); req_mul = 2'(mu);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic request_clr(int m, int d);
        err_clr = 1;
        request(m, d, 0);
        err_clr = 0;
    endtask

    task automatic wr_div8(bit v);
        div8_wr = 1; div8_wdata = v;
        @(negedge clk);
        div8_wr = 0;
    endtask

    task automatic wr_osc(int v);
        osc_wr = 1; osc_wdata = 3'(v);
        @(negedge clk);
        osc_wr = 0;
    endtask

    task automatic clr;
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1", "mode", int'(mode), 0);
        chk("R1", "cpu_div", int'(cpu_div), 3);
        chk("R1", "flag", int'(div8_flag), 1);
        chk("R1", "enables", int'({main_en, sub_en, pll_en, oco_en}), 8);
        chk("R1", "err", int'(req_err), 0);

        request(0, 1, 0);
        chk("R2", "med div2", int'(cpu_div), 1);
        request(1, 0, 0);
        chk("R2", "high div", int'(cpu_div), 0);
        chk("R2", "high src", int'(cpu_src), 0);

        pll_rdy = 0;
        request(2, 0, 3);
        chk("R8", "pll not ready", int'(mode), 1);
        chk("R8", "err on not ready", int'(req_err), 1);
        clr();
        chk("R9", "err cleared", int'(req_err), 0);
        pll_rdy = 1;
        request(2, 0, 3);
        chk("R3", "pll mode", int'(mode), 2);
        chk("R3", "pll mul", int'(pll_mul), 3);
        chk("R3", "pll src", int'(cpu_src), 2);
        request(0, 3, 0);
        chk("R3", "pll to med rejected", int'(mode), 2);
        clr();
        request(1, 0, 0);
        chk("R3", "pll to high", int'(mode), 1);

        wr_osc(1);
        chk("R11", "sub enable", int'(sub_en), 1);
        request(3, 0, 0);
        chk("R10", "low per main", int'(per_oco), 0);
        wr_osc(5);
        chk("R10", "low per oco", int'(per_oco), 1);
        request(5, 0, 0);
        chk("R6", "low to oco rejected", int'(mode), 3);
        clr();
        request(4, 0, 0);
        chk("R5", "lpd mode", int'(mode), 4);
        chk("R5", "lpd main off", int'(main_en), 0);
        chk("R5", "lpd flag", int'(div8_flag), 1);
        wr_div8(0);
        chk("R13", "lpd flag write ignored", int'(div8_flag), 1);
        request(6, 0, 0);
        chk("R6", "lpd to ocolp rejected", int'(mode), 4);
        clr();
        request(1, 0, 0);
        chk("R5", "lpd to high rejected", int'(mode), 4);
        clr();
        request(0, 3, 0);
        chk("R5", "lpd to med8", int'(mode), 0);

        request(5, 4, 0);
        chk("R4", "oco src", int'(cpu_src), 3);
        chk("R4", "oco div16", int'(cpu_div), 4);
        chk("R4", "oco periph", int'(per_oco), 1);
        request(0, 3, 0);
        chk("R7", "oco exit without flag", int'(mode), 5);
        clr();
        wr_div8(1);
        chk("R13", "flag write in oco", int'(cpu_div), 3);
        request(1, 0, 0);
        chk("R7", "oco to high rejected", int'(mode), 5);
        clr();
        request(0, 3, 0);
        chk("R7", "oco to med8", int'(mode), 0);

        request(5, 0, 0);
        request(6, 0, 0);
        chk("R11", "ocolp main off", int'(main_en), 0);
        chk("R4", "ocolp keeps div", int'(cpu_div), 0);
        request(3, 0, 0);
        chk("R6", "ocolp to low rejected", int'(mode), 6);
        clr();
        request(5, 0, 0);
        wr_div8(1);
        request(0, 3, 0);
        chk("R7", "back to med", int'(mode), 0);

        request(0, 5, 0);
        chk("R12", "div5 rejected", int'(cpu_div), 3);
        clr();
        request(7, 0, 0);
        chk("R12", "code7 rejected", int'(mode), 0);
        request_clr(0, 0);
        chk("R9", "reject beats clear", int'(req_err), 1);
        clr();
        sub_rdy = 0;
        request(3, 0, 0);
        chk("R8", "sub not ready", int'(mode), 0);
        sub_rdy = 1;
        clr();

        for (int i = 0; i < 4000; i++) begin
            req_valid  = ($urandom_range(0, 2) == 0);
            req_mode   = 3'($urandom_range(0, 7));
            req_div    = ($urandom_range(0, 2) == 0) ? 3'd3 : 3'($urandom_range(0, 5));
            req_mul    = 2'($urandom_range(0, 3));
            div8_wr    = ($urandom_range(0, 4) == 0);
            div8_wdata = 1'($urandom_range(0, 1));
            osc_wr     = ($urandom_range(0, 9) == 0);
            osc_wdata  = 3'($urandom_range(0, 7));
            err_clr    = ($urandom_range(0, 3) == 0);
            main_rdy   = ($urandom_range(0, 7) != 0);
            sub_rdy    = ($urandom_range(0, 7) != 0);
            pll_rdy    = ($urandom_range(0, 7) != 0);
            oco_rdy    = ($urandom_range(0, 7) != 0);
            @(negedge clk);
        end
        req_valid = 0; div8_wr = 0; osc_wr = 0; err_clr = 0;
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule